// File: doc/BRIEF.md
# Sleep and Lock Power Sequencer

This block is the power-mode controller of a codec core. It watches an external reset pin and a sleep pin, both brought into the clock domain by two-flop synchronizers. It decides when the core's clock-enable may be removed and when the core is ready for work. Leaving sleep also starts the coarse frequency lock of the clock multiplier. Here the lock is modelled as a fixed hold of `LOCK_CYCLES` clock cycles, and the core stays frozen for the whole hold. After a power-up reset the core is not usable until one complete sleep pulse and its lock hold have finished.

The controller measures the width of each synchronized reset and sleep pulse and rejects pulses shorter than `MIN_PULSE` cycles. It grants a one-cycle START request only when the core is idle and the host has written the Load bit since the last wake. It raises a sticky error flag on protocol violations: short pulses, a sleep request during the lock hold, and host traffic while the core is entering sleep, asleep or locking. Only a valid reset pulse clears that flag.

The states are NEED_LOCK (after reset, clocked but not ready), IDLE (ready), ENTER (sleep pin high, pulse still shorter than the minimum), SLEEP (clock frozen, valid pulse held) and LOCK (clock frozen, lock hold running). The transitions are as follows. NEED_LOCK or IDLE goes to ENTER when the sleep pin rises. ENTER goes to SLEEP when the pulse reaches the minimum width. ENTER goes back to its origin on a short release. ENTER or SLEEP goes to LOCK on a valid release. LOCK goes to IDLE when the hold ends. Any state goes to NEED_LOCK on a valid reset release.

Top module: `sleep_lock_seq`

## Requirements
- R1: After the block reset `rst_ni`, the outputs are ready_o=0, clk_en_o=1, lock_busy_o=0, err_o=0 and start_ok_o=0.
- R2: A synchronized sleep pulse of at least 8 cycles (MIN_PULSE), begun in NEED_LOCK or IDLE, sets lock_busy_o for exactly 5000 cycles (LOCK_CYCLES) after its release. clk_en_o is 0 while the valid pulse is held and during the hold. After the hold, ready_o=1 and clk_en_o=1.
- R3: A sleep pulse shorter than 8 cycles sets err_o and starts no lock hold. The block returns to the state it came from, and an already-loaded START remains grantable.
- R4: A reset-pin pulse of at least 8 cycles acts at its release: err_o clears, ready_o drops to 0 and the Load bit clears. A shorter reset pulse sets err_o and changes nothing else.
- R5: A host access or Load write while entering sleep, asleep or in the lock hold sets err_o. err_o stays set until a valid reset pulse.
- R6: A sleep pin rise during the lock hold sets err_o and neither restarts nor extends the hold.
- R7: start_ok_o is high for one cycle, the cycle after a start_i request, when the block is in IDLE and the Load bit has been written since the last wake.
- R8: A START request made outside IDLE, or without a Load write since the last wake or reset, is dropped without a grant and without setting err_o.
- R9: A Load write during the lock hold does not set the Load bit, so a following START is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Block reset, active low, asynchronous |
| reset_pin_i | input | 1 | External reset pin, active high, asynchronous to clk_i |
| sleep_pin_i | input | 1 | External sleep pin, active high, asynchronous to clk_i |
| host_acc_i | input | 1 | One-cycle strobe for any host register access |
| load_wr_i | input | 1 | One-cycle strobe for a host write of the Load bit |
| start_i | input | 1 | One-cycle START request |
| clk_en_o | output | 1 | Clock-enable to the core storage |
| ready_o | output | 1 | Core idle and operational |
| lock_busy_o | output | 1 | Lock hold in progress |
| start_ok_o | output | 1 | START granted, one cycle |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that the host strobes are synchronous to clk_i and last one cycle. They also assume that the sleep pin is never raised while the reset pin is held. The bench drives every input on the falling clock edge and pulses the strobes for exactly one cycle. It keeps reset and sleep pulses apart, so each pin's synchronized level has the width that was driven.

// File: rtl/sls_pkg.sv
package sls_pkg;
    typedef enum logic [2:0] {
        ST_NEED_LOCK,
        ST_IDLE,
        ST_ENTER,
        ST_SLEEP,
        ST_LOCK
    } sls_state_e;

    localparam int CH_SLP = 0;
    localparam int CH_RST = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/sls_sync.sv
module sls_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[b];
                s2_q <= s1_q;
            end
        end
        assign q_o[b] = s2_q;
    end
endmodule

// File: rtl/sls_pulse_meter.sv
module sls_pulse_meter #(
    parameter int MIN_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_ok_o,
    output logic fall_short_o,
    output logic held_ok_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LEN_MAX = CW'(MIN_CYC);

    logic [CW-1:0] len_q;
    logic          lvl_d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            len_q   <= '0;
            lvl_d_q <= 1'b0;
        end else begin
            lvl_d_q <= lvl_i;
            if (!lvl_i)
                len_q <= '0;
            else if (len_q != LEN_MAX)
                len_q <= len_q + 1'b1;
        end
    end

    logic fall;
    assign fall         = !lvl_i && lvl_d_q;
    assign rise_o       = lvl_i && !lvl_d_q;
    assign fall_ok_o    = fall && (len_q == LEN_MAX);
    assign fall_short_o = fall && (len_q != LEN_MAX);
    assign held_ok_o    = lvl_i && (len_q == LEN_MAX);

    // R3: the width count saturates and never runs past the minimum
    p_len_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        len_q <= LEN_MAX);
    // R3: a level that stays high keeps counting up to the limit
    p_len_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_i && lvl_d_q && (len_q != LEN_MAX) |=> len_q != '0);
endmodule

// File: rtl/sls_lock_timer.sv
module sls_lock_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == LAST)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o = run_q;
    assign done_o = run_q && (cnt_q == LAST) && !start_i;

    // R2: a load always begins the hold from zero
    p_load_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> run_q && (cnt_q == '0));
    // R2: the count never passes its terminal value
    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
endmodule

// File: rtl/sleep_lock_seq.sv
module sleep_lock_seq
    import sls_pkg::*;
#(
    parameter int MIN_PULSE   = 8,
    parameter int LOCK_CYCLES = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic reset_pin_i,
    input  logic sleep_pin_i,
    input  logic host_acc_i,
    input  logic load_wr_i,
    input  logic start_i,
    output logic clk_en_o,
    output logic ready_o,
    output logic lock_busy_o,
    output logic start_ok_o,
    output logic err_o
);
    logic [N_CH-1:0] lvl_s, rise_v, fall_ok_v, fall_short_v, held_ok_v;

    sls_sync #(.W(N_CH)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({reset_pin_i, sleep_pin_i}),
        .q_o   (lvl_s)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_meter
        sls_pulse_meter #(.MIN_CYC(MIN_PULSE)) i_meter (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .lvl_i       (lvl_s[c]),
            .rise_o      (rise_v[c]),
            .fall_ok_o   (fall_ok_v[c]),
            .fall_short_o(fall_short_v[c]),
            .held_ok_o   (held_ok_v[c])
        );
    end

    logic slp_rise, slp_ok, slp_short, slp_held, rst_ok, rst_short;
    assign slp_rise  = rise_v[CH_SLP];
    assign slp_ok    = fall_ok_v[CH_SLP];
    assign slp_short = fall_short_v[CH_SLP];
    assign slp_held  = held_ok_v[CH_SLP];
    assign rst_ok    = fall_ok_v[CH_RST];
    assign rst_short = fall_short_v[CH_RST];

    sls_state_e state_q, state_d;
    logic lock_go, lock_done, lock_run;
    logic load_q, err_q, booted_q, grant_q;

    sls_lock_timer #(.CYCLES(LOCK_CYCLES)) i_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(lock_go),
        .busy_o (lock_run),
        .done_o (lock_done)
    );

    always_comb begin
        state_d = state_q;
        lock_go = 1'b0;
        unique case (state_q)
            ST_NEED_LOCK, ST_IDLE: begin
                if (slp_rise) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                if (slp_ok) begin
                    state_d = ST_LOCK;
                    lock_go = 1'b1;
                end else if (slp_short) begin
                    state_d = booted_q ? ST_IDLE : ST_NEED_LOCK;
                end else if (slp_held) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (slp_ok) begin
                    state_d = ST_LOCK;
                    lock_go = 1'b1;
                end
            end
            ST_LOCK: begin
                if (lock_done) state_d = ST_IDLE;
            end
            default: state_d = ST_NEED_LOCK;
        endcase
        if (rst_ok) begin
            state_d = ST_NEED_LOCK;
            lock_go = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_NEED_LOCK;
        else         state_q <= state_d;
    end

    logic in_sleep, host_bad, err_set;
    assign in_sleep = (state_q == ST_ENTER) || (state_q == ST_SLEEP) || (state_q == ST_LOCK);
    assign host_bad = (host_acc_i || load_wr_i) && in_sleep;
    assign err_set  = host_bad || slp_short || rst_short ||
                      (slp_rise && (state_q == ST_LOCK));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            load_q   <= 1'b0;
            err_q    <= 1'b0;
            booted_q <= 1'b0;
            grant_q  <= 1'b0;
        end else begin
            grant_q <= start_i && (state_q == ST_IDLE) && load_q && !rst_ok;
            if (rst_ok)        err_q <= 1'b0;
            else if (err_set)  err_q <= 1'b1;
            if (rst_ok || lock_go)            load_q <= 1'b0;
            else if (load_wr_i && !in_sleep)  load_q <= 1'b1;
            if (rst_ok)                                   booted_q <= 1'b0;
            else if (lock_done && state_q == ST_LOCK)     booted_q <= 1'b1;
        end
    end

    always_comb begin
        clk_en_o    = !((state_q == ST_SLEEP) || (state_q == ST_LOCK));
        ready_o     = (state_q == ST_IDLE);
        lock_busy_o = (state_q == ST_LOCK);
        start_ok_o  = grant_q;
        err_o       = err_q;
    end

    // R5: the error flag only drops on a valid reset release
    p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o && !rst_ok |=> err_o);
    // R2: leaving the lock hold, other than by reset, lands in IDLE
    p_lock_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lock_busy_o) && !$past(rst_ok) |-> ready_o);
    // R2: the hold runs with the timer active
    p_lock_timer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_busy_o |-> lock_run);
    // R3: a short pulse from ENTER starts no hold
    p_short_no_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slp_short && (state_q == ST_ENTER) |=> !lock_busy_o);
    // R4: a valid reset release clears the error and readiness
    p_rst_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ok |=> !err_o && !ready_o);
    // R7: a grant follows a request made while ready
    p_grant_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_ok_o |-> $past(start_i) && $past(ready_o));
endmodule

// File: tb/test_sleep_lock_seq.sv
module test_sleep_lock_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_pin = 1'b0, sleep_pin = 1'b0, host_acc = 1'b0, load_wr = 1'b0, start = 1'b0;
    logic clk_en, ready, lock_busy, start_ok, err;

    always #2.5 clk = ~clk;

    sleep_lock_seq i_sleep_lock_seq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reset_pin_i(reset_pin),
        .sleep_pin_i(sleep_pin),
        .host_acc_i (host_acc),
        .load_wr_i  (load_wr),
        .start_i    (start),
        .clk_en_o   (clk_en),
        .ready_o    (ready),
        .lock_busy_o(lock_busy),
        .start_ok_o (start_ok),
        .err_o      (err)
    );

    int n_chk = 0, n_fail = 0;
    int busy_cnt = 0, grant_cnt = 0;
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (lock_busy) busy_cnt++;
        if (start_ok)  grant_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_sleep(input int n, input int settle);
        sleep_pin = 1'b1; cyc(n); sleep_pin = 1'b0; cyc(settle);
    endtask

    task automatic pin_reset(input int n);
        reset_pin = 1'b1; cyc(n); reset_pin = 1'b0; cyc(6);
    endtask

    task automatic pulse_load();
        load_wr = 1'b1; cyc(1); load_wr = 1'b0; cyc(2);
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc(1); start = 1'b0; cyc(3);
    endtask

    localparam logic [1:0] OP_STA = 2'd0, OP_SLP = 2'd1, OP_LD = 2'd2, OP_RST = 2'd3;
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  n;
        logic        rdy;
        logic        er;
        logic        gr;
        logic [12:0] lk;
    } vec_t;
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{OP_STA, 8'd0,  1'b0, 1'b0, 1'b0, 13'd0},    // R8 not idle
        '{OP_SLP, 8'd8,  1'b1, 1'b0, 1'b0, 13'd5000}, // R2 mandatory lock
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b0, 13'd0},    // R8 no load
        '{OP_LD,  8'd0,  1'b1, 1'b0, 1'b0, 13'd0},
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b1, 13'd0},    // R7
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b1, 13'd0},    // R7 load persists
        '{OP_SLP, 8'd20, 1'b1, 1'b0, 1'b0, 13'd5000}, // R2 long pulse
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b0, 13'd0},    // R8 wake cleared load
        '{OP_LD,  8'd0,  1'b1, 1'b0, 1'b0, 13'd0},
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b1, 13'd0},    // R7
        '{OP_SLP, 8'd7,  1'b1, 1'b1, 1'b0, 13'd0},    // R3 short sleep
        '{OP_STA, 8'd0,  1'b1, 1'b1, 1'b1, 13'd0},    // R3 no effect
        '{OP_RST, 8'd7,  1'b1, 1'b1, 1'b0, 13'd0},    // R4 short reset
        '{OP_RST, 8'd8,  1'b0, 1'b0, 1'b0, 13'd0},    // R4 valid reset
        '{OP_STA, 8'd0,  1'b0, 1'b0, 1'b0, 13'd0},    // R8
        '{OP_SLP, 8'd8,  1'b1, 1'b0, 1'b0, 13'd5000}, // R2
        '{OP_STA, 8'd0,  1'b1, 1'b0, 1'b0, 13'd0}     // R8 reset cleared load
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        // R1 reset state
        chk("R1 ready", ready, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 lock_busy", lock_busy, 0);
        chk("R1 err", err, 0);
        chk("R1 start_ok", start_ok, 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 ready after release", ready, 0);
        chk("R1 err after release", err, 0);

        for (int i = 0; i < NV; i++) begin
            busy_cnt = 0; grant_cnt = 0;
            unique case (VECS[i].op)
                OP_STA: pulse_start();
                OP_SLP: pin_sleep(int'(VECS[i].n), 5030);
                OP_LD:  pulse_load();
                OP_RST: pin_reset(int'(VECS[i].n));
                default: ;
            endcase
            chk($sformatf("vec%0d R2/R3/R4 ready", i), ready, int'(VECS[i].rdy));
            chk($sformatf("vec%0d R3/R4/R8 err", i), err, int'(VECS[i].er));
            chk($sformatf("vec%0d R7/R8 grant", i), grant_cnt, int'(VECS[i].gr));
            chk($sformatf("vec%0d R2 lock cycles", i), busy_cnt, int'(VECS[i].lk));
        end

        // R2 and R5: host access while asleep
        sleep_pin = 1'b1; cyc(14);
        chk("R2 clk_en frozen in sleep", clk_en, 0);
        host_acc = 1'b1; cyc(1); host_acc = 1'b0; cyc(2);
        chk("R5 err on host access in sleep", err, 1);
        busy_cnt = 0;
        sleep_pin = 1'b0; cyc(5030);
        chk("R2 lock cycles", busy_cnt, 5000);
        chk("R2 ready after lock", ready, 1);
        chk("R2 clk_en after lock", clk_en, 1);
        chk("R5 err sticky", err, 1);
        pin_reset(8);
        chk("R4 err cleared", err, 0);

        // R6: sleep rise during lock hold
        busy_cnt = 0;
        pin_sleep(8, 100);
        pin_sleep(8, 5030);
        chk("R6 err on sleep in lock", err, 1);
        chk("R6 lock not extended", busy_cnt, 5000);
        chk("R6 ready", ready, 1);
        pin_reset(8);
        pin_sleep(8, 5030);
        chk("R2 ready before R9 test", ready, 1);

        // R9: load write during lock ignored
        pulse_load();
        pin_sleep(8, 50);
        pulse_load();
        cyc(5030);
        chk("R5 err on load in lock", err, 1);
        grant_cnt = 0;
        pulse_start();
        chk("R9 start refused", grant_cnt, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule